// File: doc/BRIEF.md
# Processor Event Trace Recorder

This block sits beside a soft processor and keeps a running log of what the core does, without copying its whole register file in one clock. It logs two kinds of event. When the core leaves straight-line flow because a branch or jump is taken, the new program counter is logged. When the core writes its register file, the destination number and the value are logged. Each event becomes one tagged record in an on-chip dual-port memory. The capture side fills the memory while the host side reads it back on its own port.

The host arms the recorder, runs the program, and then reads the records in slot order. It compares the recorded sequence of jump targets and register writes against a trace from simulation. A 16-bit sequence number stamped on every event shows the host where records went missing. A one-cycle trigger pulse marks the moment capture freezes, so an external scope or logic analyser can show the wires around that point. Capture either stops when the memory is full, or wraps and keeps the newest records.

Top module: `cpu_event_tracer`

## Requirements
- R1: After reset, capture is inactive, the done flag, trigger, entry count and write pointer are all 0, and no record is written to memory.
- R2: A cycle with `arm` high clears the entry count, the write pointer and the sequence counter, and starts capture from the next cycle. Events presented in the arm cycle are not logged. `arm` takes priority over `stop`.
- R3: A register-file write while capturing stores one record with tag 1, payload equal to the written value, and index equal to the destination register. Records go to consecutive slots, starting at slot 0 after arm.
- R4: A taken branch or jump while capturing stores one record with tag 0, payload equal to the new PC, and index 0.
- R5: When a jump and a register write arrive in the same cycle, the PC record takes slot k and the register record takes slot k+1.
- R6: Every logged event carries a 16-bit sequence number. It is 0 for the first event after arm, rises by one per event, and wraps from 65535 to 0.
- R7: At most one record is written per cycle. Up to two records wait in a skid buffer, kept in arrival order. A record that would exceed those two is discarded, but its sequence number is still used up, which leaves a visible gap.
- R8: `stop` while capturing clears `cap_active` and sets `cap_done` from the next cycle. Buffered and newly presented events are then discarded.
- R9: With `oneshot` high, the write that fills the last slot ends capture and sets `cap_done`. The count stays at the memory depth and no slot is overwritten.
- R10: With `oneshot` low, the write pointer wraps and the oldest slots are overwritten. The count saturates at the memory depth and capture continues.
- R11: `scope_trig` is high for exactly one cycle: the first cycle in which `cap_done` is 1.
- R12: A read with `rd_en` high returns the record at `rd_addr` after one clock edge. With `rd_en` low, the read outputs hold their value.
- R13: While capture is inactive, CPU events change neither the count, the write pointer nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_pc | input | 32 | New PC value, valid with `cpu_jump` |
| cpu_jump | input | 1 | Branch or jump taken this cycle |
| cpu_rf_we | input | 1 | Register file write strobe |
| cpu_rf_idx | input | 5 | Destination register number |
| cpu_rf_data | input | 32 | Value written to the register file |
| arm | input | 1 | Clear and start capture |
| stop | input | 1 | Freeze capture |
| oneshot | input | 1 | 1: stop when full, 0: wrap |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | DEPTH_LOG2 | Host read slot |
| rd_tag | output | 1 | Record tag (0 PC, 1 register) |
| rd_payload | output | 32 | Record payload |
| rd_idx | output | 5 | Register index of record |
| rd_seq | output | 16 | Record sequence number |
| rec_count | output | DEPTH_LOG2+1 | Number of valid records |
| wr_ptr | output | DEPTH_LOG2 | Next slot to be written |
| cap_active | output | 1 | Capture running |
| cap_done | output | 1 | Capture frozen |
| scope_trig | output | 1 | One-cycle trigger pulse |

## Verification
The bench builds the recorder with `DEPTH_LOG2 = 4`, so the memory has sixteen slots. That size lets a short run fill the memory, end a one-shot capture, and wrap the pointer more than once. It also keeps a sweep of over 65536 single-event cycles short enough to check that the sequence number rolls over. Back-to-back cycles with both a jump and a register write overflow the two-entry skid buffer, which shows the dropped record and the gap in the sequence numbers.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int PAYLOAD_W = 32;
    localparam int IDX_W     = 5;
    localparam int SEQ_W     = 16;
    localparam int SKID_N    = 2;

    localparam logic TAG_PC  = 1'b0;
    localparam logic TAG_REG = 1'b1;

    typedef struct packed {
        logic                 tag;
        logic [PAYLOAD_W-1:0] payload;
        logic [IDX_W-1:0]     idx;
        logic [SEQ_W-1:0]     seq;
    } trc_rec_t;

    localparam int REC_W = $bits(trc_rec_t);
endpackage

// File: rtl/trc_merge.sv
module trc_merge
    import trc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic                 pc_ev,
    input  logic [PAYLOAD_W-1:0] pc_val,
    input  logic                 reg_ev,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [PAYLOAD_W-1:0] reg_val,
    output logic                 wr_valid,
    output trc_rec_t             wr_rec
);
    typedef struct packed {
        trc_rec_t         slot0;
        trc_rec_t         slot1;
        logic [1:0]       fill;
        logic [SEQ_W-1:0] seq;
    } merge_st_t;

    merge_st_t st_q, st_d;
    trc_rec_t  items [4];
    logic [2:0]       n;
    logic [SEQ_W-1:0] seq_n;

    always_comb begin
        st_d     = st_q;
        items[0] = st_q.slot0;
        items[1] = st_q.slot1;
        items[2] = '0;
        items[3] = '0;
        n        = {1'b0, st_q.fill};
        seq_n    = st_q.seq;

        if (en) begin
            // older buffered records first, then PC record, then register record
            if (pc_ev) begin
                items[n[1:0]] = '{tag: TAG_PC, payload: pc_val, idx: '0, seq: seq_n};
                n     = n + 3'd1;
                seq_n = seq_n + SEQ_W'(1);
            end
            if (reg_ev) begin
                items[n[1:0]] = '{tag: TAG_REG, payload: reg_val, idx: reg_idx, seq: seq_n};
                n     = n + 3'd1;
                seq_n = seq_n + SEQ_W'(1);
            end
        end

        wr_valid = en && (n != 3'd0);
        wr_rec   = items[0];

        if (!en || n == 3'd0) begin
            st_d.fill = 2'd0;
        end else begin
            st_d.slot0 = items[1];
            st_d.slot1 = items[2];
            // a fourth pending record has no room and is dropped
            st_d.fill  = (n >= 3'd3) ? 2'(SKID_N) : (n[1:0] - 2'd1);
        end

        st_d.seq = clear ? '0 : seq_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic                  stop,
    input  logic                  oneshot,
    input  logic                  wr_valid,
    output logic                  active,
    output logic                  done,
    output logic                  trig,
    output logic [DEPTH_LOG2-1:0] wptr,
    output logic [DEPTH_LOG2:0]   count
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2:0] CNT_FULL = DEPTH[DEPTH_LOG2:0];
    localparam logic [DEPTH_LOG2:0] CNT_LAST = CNT_FULL - 1'b1;

    typedef struct packed {
        logic                  active;
        logic                  done;
        logic                  trig;
        logic [DEPTH_LOG2-1:0] wptr;
        logic [DEPTH_LOG2:0]   count;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        if (arm) begin
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
            st_d.wptr   = '0;
            st_d.count  = '0;
        end else if (st_q.active) begin
            if (stop) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
                st_d.trig   = 1'b1;
            end else if (wr_valid) begin
                st_d.wptr = st_q.wptr + DEPTH_LOG2'(1);
                if (st_q.count != CNT_FULL)
                    st_d.count = st_q.count + (DEPTH_LOG2+1)'(1);
                if (oneshot && st_q.count == CNT_LAST) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.trig   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign done   = st_q.done;
    assign trig   = st_q.trig;
    assign wptr   = st_q.wptr;
    assign count  = st_q.count;
endmodule

// File: rtl/trc_ram.sv
module trc_ram
    import trc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  trc_rec_t          wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output trc_rec_t          rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    trc_rec_t mem [DEPTH];
    trc_rec_t rd_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rd_q <= '0;
        else if (re) rd_q <= mem[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/cpu_event_tracer.sv
module cpu_event_tracer
    import trc_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PAYLOAD_W-1:0]  cpu_pc,
    input  logic                  cpu_jump,
    input  logic                  cpu_rf_we,
    input  logic [IDX_W-1:0]      cpu_rf_idx,
    input  logic [PAYLOAD_W-1:0]  cpu_rf_data,
    input  logic                  arm,
    input  logic                  stop,
    input  logic                  oneshot,
    input  logic                  rd_en,
    input  logic [DEPTH_LOG2-1:0] rd_addr,
    output logic                  rd_tag,
    output logic [PAYLOAD_W-1:0]  rd_payload,
    output logic [IDX_W-1:0]      rd_idx,
    output logic [SEQ_W-1:0]      rd_seq,
    output logic [DEPTH_LOG2:0]   rec_count,
    output logic [DEPTH_LOG2-1:0] wr_ptr,
    output logic                  cap_active,
    output logic                  cap_done,
    output logic                  scope_trig
);
    logic     take_en;
    logic     wr_valid;
    trc_rec_t wr_rec;
    trc_rec_t rd_rec;

    assign take_en = cap_active && !stop && !arm;

    trc_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (arm),
        .en       (take_en),
        .pc_ev    (cpu_jump),
        .pc_val   (cpu_pc),
        .reg_ev   (cpu_rf_we),
        .reg_idx  (cpu_rf_idx),
        .reg_val  (cpu_rf_data),
        .wr_valid (wr_valid),
        .wr_rec   (wr_rec)
    );

    trc_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .stop     (stop),
        .oneshot  (oneshot),
        .wr_valid (wr_valid),
        .active   (cap_active),
        .done     (cap_done),
        .trig     (scope_trig),
        .wptr     (wr_ptr),
        .count    (rec_count)
    );

    trc_ram #(.ADDR_W(DEPTH_LOG2)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_valid),
        .waddr (wr_ptr),
        .wdata (wr_rec),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_rec)
    );

    assign rd_tag     = rd_rec.tag;
    assign rd_payload = rd_rec.payload;
    assign rd_idx     = rd_rec.idx;
    assign rd_seq     = rd_rec.seq;
endmodule

// File: rtl/cpu_event_tracer_chk.sv
module cpu_event_tracer_chk #(
    parameter int DEPTH_LOG2 = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  arm,
    input logic                  stop,
    input logic                  cap_active,
    input logic                  cap_done,
    input logic                  scope_trig,
    input logic [DEPTH_LOG2:0]   rec_count,
    input logic [DEPTH_LOG2-1:0] wr_ptr
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_count <= (DEPTH_LOG2+1)'(DEPTH));

    assert_active_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_active && cap_done));

    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (rec_count == '0 && wr_ptr == '0 && cap_active && !cap_done));

    assert_stop_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_active && stop && !arm) |=> (cap_done && !cap_active));

    assert_trig_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_done) |-> scope_trig);

    assert_trig_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scope_trig |=> !scope_trig);

    assert_idle_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_active && !arm) |=> ($stable(rec_count) && $stable(wr_ptr)));
endmodule

bind cpu_event_tracer cpu_event_tracer_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .stop       (stop),
    .cap_active (cap_active),
    .cap_done   (cap_done),
    .scope_trig (scope_trig),
    .rec_count  (rec_count),
    .wr_ptr     (wr_ptr)
);

// File: tb/cpu_event_tracer_test.sv
module cpu_event_tracer_test;
    import trc_pkg::*;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic [31:0]          cpu_pc = '0;
    logic                 cpu_jump = 1'b0;
    logic                 cpu_rf_we = 1'b0;
    logic [4:0]           cpu_rf_idx = '0;
    logic [31:0]          cpu_rf_data = '0;
    logic                 arm = 1'b0, stop = 1'b0, oneshot = 1'b0;
    logic                 rd_en = 1'b0;
    logic [AW-1:0]        rd_addr = '0;
    logic                 rd_tag;
    logic [31:0]          rd_payload;
    logic [4:0]           rd_idx;
    logic [15:0]          rd_seq;
    logic [AW:0]          rec_count;
    logic [AW-1:0]        wr_ptr;
    logic                 cap_active, cap_done, scope_trig;

    cpu_event_tracer #(.DEPTH_LOG2(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_pc(cpu_pc), .cpu_jump(cpu_jump),
        .cpu_rf_we(cpu_rf_we), .cpu_rf_idx(cpu_rf_idx), .cpu_rf_data(cpu_rf_data),
        .arm(arm), .stop(stop), .oneshot(oneshot), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_tag(rd_tag), .rd_payload(rd_payload), .rd_idx(rd_idx), .rd_seq(rd_seq),
        .rec_count(rec_count), .wr_ptr(wr_ptr), .cap_active(cap_active),
        .cap_done(cap_done), .scope_trig(scope_trig)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    int unsigned exp_seq = 0;
    trc_rec_t    exp_q [$];

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic ev(bit j, logic [31:0] pc, bit w, logic [4:0] ix, logic [31:0] d);
        cpu_jump = j; cpu_pc = pc; cpu_rf_we = w; cpu_rf_idx = ix; cpu_rf_data = d;
        @(posedge clk); @(negedge clk);
        cpu_jump = 1'b0; cpu_rf_we = 1'b0;
    endtask

    // driver side of the scoreboard
    task automatic push_pc(logic [31:0] pc);
        exp_q.push_back('{tag: TAG_PC, payload: pc, idx: '0, seq: exp_seq[15:0]});
        exp_seq++;
    endtask

    task automatic push_reg(logic [4:0] ix, logic [31:0] d);
        exp_q.push_back('{tag: TAG_REG, payload: d, idx: ix, seq: exp_seq[15:0]});
        exp_seq++;
    endtask

    task automatic pulse_arm();
        arm = 1'b1; @(posedge clk); @(negedge clk); arm = 1'b0;
        exp_seq = 0; exp_q.delete();
    endtask

    task automatic read_slot(logic [AW-1:0] a, output trc_rec_t r);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        r = '{tag: rd_tag, payload: rd_payload, idx: rd_idx, seq: rd_seq};
    endtask

    // monitor side: reads slots back and pops the expectation queue
    task automatic drain_compare(string req, int first, int n);
        for (int i = 0; i < n; i++) begin
            trc_rec_t got, exp;
            read_slot(AW'(first + i), got);
            exp = exp_q.pop_front();
            chk(req, $sformatf("slot %0d record", first + i), 64'(got), 64'(exp));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        trc_rec_t r;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "cap_active", 64'(cap_active), 0);
        chk("R1", "cap_done",   64'(cap_done), 0);
        chk("R1", "rec_count",  64'(rec_count), 0);
        chk("R1", "wr_ptr",     64'(wr_ptr), 0);
        chk("R1", "scope_trig", 64'(scope_trig), 0);

        // R13 events before arm are ignored
        ev(1, 32'h40, 1, 5'd3, 32'h33);
        chk("R13", "count before arm", 64'(rec_count), 0);

        // R2 arm with an event in the same cycle
        cpu_rf_we = 1'b1; cpu_rf_idx = 5'd9; cpu_rf_data = 32'h99;
        pulse_arm();
        cpu_rf_we = 1'b0;
        idle(1);
        chk("R2", "count after arm", 64'(rec_count), 0);
        chk("R2", "active after arm", 64'(cap_active), 1);

        // R3 R4 R5 R6 mixed stream
        ev(0, 0, 1, 5'd1, 32'hA1);          push_reg(5'd1, 32'hA1);
        ev(0, 0, 1, 5'd2, 32'hA2);          push_reg(5'd2, 32'hA2);
        ev(0, 0, 1, 5'd31, 32'hDEADBEEF);   push_reg(5'd31, 32'hDEADBEEF);
        ev(1, 32'h100, 0, 0, 0);            push_pc(32'h100);
        ev(1, 32'h200, 0, 0, 0);            push_pc(32'h200);
        ev(1, 32'h300, 1, 5'd7, 32'h77);    push_pc(32'h300); push_reg(5'd7, 32'h77);
        idle(2);
        chk("R3", "count mixed", 64'(rec_count), 7);
        drain_compare("R3_R4_R5_R6", 0, 7);

        // R12 read output holds while rd_en is low
        read_slot(AW'(0), r);
        rd_addr = AW'(3);
        idle(2);
        chk("R12", "hold payload", 64'(rd_payload), 64'h A1);

        // R8 R11 stop
        stop = 1'b1; @(posedge clk); @(negedge clk); stop = 1'b0;
        chk("R8", "done after stop", 64'(cap_done), 1);
        chk("R8", "active after stop", 64'(cap_active), 0);
        chk("R11", "trig first cycle", 64'(scope_trig), 1);
        idle(1);
        chk("R11", "trig second cycle", 64'(scope_trig), 0);
        ev(1, 32'h500, 1, 5'd4, 32'h44);
        idle(1);
        chk("R13", "count frozen after stop", 64'(rec_count), 7);

        // R7 skid overflow
        pulse_arm();
        ev(1, 32'h1000, 1, 5'd1, 32'h11);
        ev(1, 32'h2000, 1, 5'd2, 32'h22);
        ev(1, 32'h3000, 1, 5'd3, 32'h33);
        push_pc(32'h1000); push_reg(5'd1, 32'h11);
        push_pc(32'h2000); push_reg(5'd2, 32'h22);
        push_pc(32'h3000);
        exp_seq++;                       // dropped register record uses seq 5
        idle(2);
        chk("R7", "count after overflow", 64'(rec_count), 5);
        ev(0, 0, 1, 5'd6, 32'h66);       push_reg(5'd6, 32'h66);
        chk("R7", "count after gap record", 64'(rec_count), 6);
        drain_compare("R7", 0, 6);

        // R9 one-shot fill
        oneshot = 1'b1;
        pulse_arm();
        for (int i = 0; i < DEPTH; i++) ev(0, 0, 1, 5'(i), 32'h500 + 32'(i));
        chk("R9", "count full", 64'(rec_count), DEPTH);
        chk("R9", "done when full", 64'(cap_done), 1);
        chk("R11", "trig when full", 64'(scope_trig), 1);
        ev(0, 0, 1, 5'd30, 32'hBAD);
        chk("R9", "count after full", 64'(rec_count), DEPTH);
        read_slot(AW'(0), r);
        chk("R9", "slot 0 kept", 64'(r.payload), 64'h500);

        // R10 wrap mode
        oneshot = 1'b0;
        pulse_arm();
        for (int i = 0; i < 20; i++) ev(0, 0, 1, 5'(i), 32'h900 + 32'(i));
        chk("R10", "count saturates", 64'(rec_count), DEPTH);
        chk("R10", "pointer wrapped", 64'(wr_ptr), 4);
        chk("R10", "still active", 64'(cap_active), 1);
        read_slot(AW'(0), r);
        chk("R10", "slot 0 overwritten", 64'(r.payload), 64'h910);
        chk("R10", "slot 0 seq", 64'(r.seq), 16);
        read_slot(AW'(4), r);
        chk("R10", "slot 4 oldest", 64'(r.payload), 64'h904);

        // R6 sequence wrap
        pulse_arm();
        for (int i = 0; i < 65538; i++) ev(0, 0, 1, 5'(i), 32'(i));
        read_slot(AW'(1), r);
        chk("R6", "seq after wrap", 64'(r.seq), 1);
        chk("R6", "payload after wrap", 64'(r.payload), 65537);
        read_slot(AW'(0), r);
        chk("R6", "seq at wrap", 64'(r.seq), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule